// File: doc/BRIEF.md
# Gated Period Timer with Prescaler

This block is a 16-bit up-counter that runs against a programmable period. Software sets the control, count and period values through a small register write port and reads them back through a combinational read port. The counter is advanced by ticks from a prescaler, which divides its source by 1, 8, 64 or 256. The source is one of three. In internal mode it is every clock cycle. In external mode it is each synchronised rising edge of an external clock pin. In gated accumulation mode it is every cycle in which the synchronised gate pin is high.

When the counter receives a tick while it equals the period, it returns to zero and sets a sticky interrupt flag. In gated mode the falling edge of the gate also sets the flag, which marks the end of one accumulation window. The interrupt output follows the flag only while the interrupt-enable bit is set. A stop-in-idle bit lets an idle input freeze counting. Writes to the count or control register clear the prescaler while the timer is enabled. A control write leaves the count unchanged.

Top module: `gated_period_timer`

## Requirements
- R1: After reset, the count, the period, the control register, the flag and `irq_o` all read zero.
- R2: Register map: address 0 is control, 1 is count, 2 is period and 3 is the flag (bit 0). When a tick arrives with count equal to period, the count becomes 0 and the flag is set. Any other tick adds one to the count.
- R3: Control bits [4:3] select the prescale ratio: value 0 divides by 1, 1 by 8, 2 by 64 and 3 by 256. With ratio N, the count advances once every N source events.
- R4: While control bit 0 (enable) is set, a write to the count or control register clears the prescaler, and no tick is issued in that cycle. A control write never alters the count.
- R5: A count-register write loads the written value, and takes priority over any increment in the same cycle.
- R6: With enable set, control bit 1 (external) clear and control bit 2 (gate) set, the count advances once per cycle while the synchronised gate is high. The gate's falling edge sets the flag.
- R7: With control bit 1 set, the count advances on each synchronised rising edge of `ext_clk_i`. In this mode the gate input has no effect on the count or the flag.
- R8: With control bit 5 (stop-in-idle) set, a high `idle_i` freezes the count, and counting resumes from the held value. With the bit clear, counting continues during idle.
- R9: The flag stays set until a write to address 3 with bit 0 set. If that clear coincides with a new flag event, the flag stays set.
- R10: `irq_o` is high exactly when the flag is set and control bit 6 (interrupt enable) is set. A control write does not clear the flag.
- R11: With enable clear, the count only changes through a count-register write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 count, 2 period, 3 flag) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address, same map |
| rd_data | output | 16 | Combinational read data |
| gate_i | input | 1 | Gate input for accumulation mode |
| ext_clk_i | input | 1 | External count clock, sampled |
| idle_i | input | 1 | Idle request |
| irq_o | output | 1 | Interrupt request |

## Verification
Two functions can fall in the same cycle: a software clear of the flag and a period match that sets it again. The bench times the clear write to land on the edge where the count wraps from the period to zero. It then checks that the flag still reads one and the count reads zero. A second collision, a count write against a running increment, is judged by the loaded value appearing unchanged after the write edge.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
    localparam int ADDR_W = 2;
    localparam int DATA_W = 16;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_CNT  = 2'd1;
    localparam logic [ADDR_W-1:0] A_PER  = 2'd2;
    localparam logic [ADDR_W-1:0] A_FLAG = 2'd3;

    typedef struct packed {
        logic       irq_en;
        logic       stop_idle;
        logic [1:0] ps;
        logic       gate;
        logic       ext;
        logic       en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/gpt_sync.sv
module gpt_sync #(
    parameter int N      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] level,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    localparam int LEN = STAGES + 1;

    for (genvar g = 0; g < N; g++) begin : g_bit
        logic [LEN-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[LEN-2:0], din[g]};
        end

        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= chain_d;
        end

        assign level[g] = chain_q[STAGES-1];
        assign rise[g]  =  chain_q[STAGES-1] & ~chain_q[STAGES];
        assign fall[g]  = ~chain_q[STAGES-1] &  chain_q[STAGES];
    end
endmodule

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic       clr_i,
    input  logic       src_i,
    input  logic [1:0] sel_i,
    output logic       tick_o
);
    localparam int STEP = 3;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_st_t;

    pre_st_t          s_d, s_q;
    logic [PRE_W-1:0] term;

    always_comb begin
        if (sel_i == 2'd3) term = {PRE_W{1'b1}};
        else               term = PRE_W'((1 << (STEP * int'(sel_i))) - 1);
    end

    always_comb begin
        s_d    = s_q;
        tick_o = 1'b0;
        if (clr_i) begin
            s_d.pre = '0;
        end else if (run_i && src_i) begin
            if (s_q.pre == term) begin
                s_d.pre = '0;
                tick_o  = 1'b1;
            end else begin
                s_d.pre = s_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/gpt_core.sv
module gpt_core
    import gpt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tick_i,
    input  logic              gfall_i,
    output ctrl_t             ctrl_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CNT_W-1:0]  per_o,
    output logic              flag_o,
    output logic              match_o
);
    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per;
        logic             flag;
    } core_st_t;

    core_st_t s_d, s_q;
    logic     wr_ctrl, wr_cnt, wr_per, wr_clr, match;

    always_comb begin
        wr_ctrl = wr_en && (wr_addr == A_CTRL);
        wr_cnt  = wr_en && (wr_addr == A_CNT);
        wr_per  = wr_en && (wr_addr == A_PER);
        wr_clr  = wr_en && (wr_addr == A_FLAG) && wr_data[0];
    end

    always_comb begin
        s_d   = s_q;
        match = 1'b0;
        if (wr_ctrl) s_d.ctrl = ctrl_t'(wr_data[CTRL_W-1:0]);
        if (wr_per)  s_d.per  = wr_data[CNT_W-1:0];
        if (wr_cnt) begin
            s_d.cnt = wr_data[CNT_W-1:0];
        end else if (tick_i) begin
            if (s_q.cnt == s_q.per) begin
                s_d.cnt = '0;
                match   = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
        if (match || gfall_i) s_d.flag = 1'b1;
        else if (wr_clr)      s_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctrl_o  = s_q.ctrl;
    assign cnt_o   = s_q.cnt;
    assign per_o   = s_q.per;
    assign flag_o  = s_q.flag;
    assign match_o = match;
endmodule

// File: rtl/gated_period_timer.sv
module gated_period_timer
    import gpt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int PRE_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              gate_i,
    input  logic              ext_clk_i,
    input  logic              idle_i,
    output logic              irq_o
);
    localparam int IDX_GATE = 0;
    localparam int IDX_EXT  = 1;
    localparam int NSYNC    = 2;

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] cnt_q, per_q;
    logic             flag_q, match_w;
    logic [NSYNC-1:0] s_lvl, s_rise, s_fall;
    logic             active, src, pre_clr, tick, gfall_evt;

    gpt_sync #(.N(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({ext_clk_i, gate_i}),
        .level (s_lvl),
        .rise  (s_rise),
        .fall  (s_fall)
    );

    always_comb begin
        active    = ctrl_q.en && !(idle_i && ctrl_q.stop_idle);
        if (ctrl_q.ext)       src = s_rise[IDX_EXT];
        else if (ctrl_q.gate) src = s_lvl[IDX_GATE];
        else                  src = 1'b1;
        pre_clr   = ctrl_q.en && wr_en && (wr_addr == A_CTRL || wr_addr == A_CNT);
        gfall_evt = active && !ctrl_q.ext && ctrl_q.gate && s_fall[IDX_GATE];
    end

    gpt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (active),
        .clr_i  (pre_clr),
        .src_i  (src),
        .sel_i  (ctrl_q.ps),
        .tick_o (tick)
    );

    gpt_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .tick_i  (tick),
        .gfall_i (gfall_evt),
        .ctrl_o  (ctrl_q),
        .cnt_o   (cnt_q),
        .per_o   (per_q),
        .flag_o  (flag_q),
        .match_o (match_w)
    );

    always_comb begin
        case (rd_addr)
            A_CTRL:  rd_data = DATA_W'(ctrl_q);
            A_CNT:   rd_data = DATA_W'(cnt_q);
            A_PER:   rd_data = DATA_W'(per_q);
            default: rd_data = DATA_W'(flag_q);
        endcase
    end

    assign irq_o = flag_q && ctrl_q.irq_en;
endmodule

// File: rtl/gpt_checker.sv
module gpt_checker
    import gpt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              flag_q,
    input logic              gfall_evt,
    input ctrl_t             ctrl_q,
    input logic              irq_o
);
    // R5: a count write lands regardless of any increment
    p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_CNT) |=> (cnt_q == $past(wr_data[CNT_W-1:0])));

    // R9: flag holds unless cleared
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(wr_en && wr_addr == A_FLAG && wr_data[0])) |=> flag_q);

    // R11: disabled counter holds without a count write
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.en && !(wr_en && wr_addr == A_CNT)) |=> $stable(cnt_q));

    // R4: an enabled control write keeps the count
    p_ctrl_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.en && wr_en && wr_addr == A_CTRL) |=> $stable(cnt_q));

    // R2: the flag rises only after a wrap to zero or a gate fall
    p_flag_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> (cnt_q == '0 || $past(gfall_evt)));

    // R10: no interrupt without the flag
    p_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> flag_q);
endmodule

bind gated_period_timer gpt_checker #(.CNT_W(CNT_W)) u_gpt_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .cnt_q     (cnt_q),
    .flag_q    (flag_q),
    .gfall_evt (gfall_evt),
    .ctrl_q    (ctrl_q),
    .irq_o     (irq_o)
);

// File: tb/gated_period_timer_bench.sv
module gated_period_timer_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        gate_i = 1'b0;
    logic        ext_clk_i = 1'b0;
    logic        idle_i = 1'b0;
    logic        irq_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gated_period_timer u_gated_period_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .gate_i(gate_i), .ext_clk_i(ext_clk_i), .idle_i(idle_i), .irq_o(irq_o)
    );

    task automatic check(input string req, input string what, input int got, input int exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0; gate_i = 1'b0; ext_clk_i = 1'b0; idle_i = 1'b0; wr_en = 1'b0;
        wait_n(3);
        rst_n = 1'b1;
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic t_reset;
        int v;
        do_reset();
        rd(0, v); check("R1", "ctrl", v, 0);
        rd(1, v); check("R1", "count", v, 0);
        rd(2, v); check("R1", "period", v, 0);
        rd(3, v); check("R1", "flag", v, 0);
        check("R1", "irq", int'(irq_o), 0);
    endtask

    task automatic t_wrap_irq;
        int v;
        do_reset();
        bus_wr(2, 16'd4);
        bus_wr(0, 16'h0001);
        wait_n(3);
        rd(1, v); check("R2", "count before wrap", v, 3);
        rd(3, v); check("R2", "flag before wrap", v, 0);
        wait_n(2);
        rd(1, v); check("R2", "count after wrap", v, 0);
        rd(3, v); check("R2", "flag after wrap", v, 1);
        check("R10", "irq masked", int'(irq_o), 0);
        bus_wr(0, 16'h0041);
        check("R10", "irq enabled", int'(irq_o), 1);
        rd(3, v); check("R10", "flag kept by ctrl write", v, 1);
        bus_wr(3, 16'h0001);
        rd(3, v); check("R9", "flag cleared", v, 0);
        check("R10", "irq after clear", int'(irq_o), 0);
    endtask

    task automatic t_ratio(input int sel, input int ratio);
        int v;
        do_reset();
        bus_wr(2, 16'hFFFF);
        bus_wr(0, 16'(1 | (sel << 3)));
        wait_n(3 * ratio);
        rd(1, v); check("R3", $sformatf("count ratio %0d", ratio), v, 3);
    endtask

    task automatic t_pre_clear;
        int v;
        do_reset();
        bus_wr(2, 16'hFFFF);
        bus_wr(0, 16'h0009);
        wait_n(5);
        bus_wr(1, 16'd100);
        wait_n(7);
        rd(1, v); check("R4", "count write cleared prescaler", v, 100);
        wait_n(1);
        rd(1, v); check("R4", "tick after full ratio", v, 101);
        wait_n(3);
        bus_wr(0, 16'h0009);
        rd(1, v); check("R4", "ctrl write keeps count", v, 101);
        wait_n(7);
        rd(1, v); check("R4", "ctrl write cleared prescaler", v, 101);
        wait_n(1);
        rd(1, v); check("R4", "tick after ctrl clear", v, 102);
    endtask

    task automatic t_load_priority;
        int v;
        do_reset();
        bus_wr(2, 16'hFFFF);
        bus_wr(0, 16'h0001);
        wait_n(3);
        bus_wr(1, 16'd50);
        rd(1, v); check("R5", "loaded value", v, 50);
        wait_n(1);
        rd(1, v); check("R5", "resumes after load", v, 51);
    endtask

    task automatic t_gated;
        int v;
        do_reset();
        bus_wr(2, 16'hFFFF);
        bus_wr(0, 16'h0005);
        wait_n(5);
        rd(1, v); check("R6", "no count with gate low", v, 0);
        gate_i = 1'b1;
        wait_n(10);
        rd(3, v); check("R6", "flag while gate high", v, 0);
        gate_i = 1'b0;
        wait_n(5);
        rd(1, v); check("R6", "accumulated cycles", v, 10);
        rd(3, v); check("R6", "flag on gate fall", v, 1);
    endtask

    task automatic t_external;
        int v;
        do_reset();
        bus_wr(2, 16'hFFFF);
        bus_wr(0, 16'h0007);
        gate_i = 1'b1;
        for (int i = 0; i < 6; i++) begin
            ext_clk_i = 1'b1; wait_n(3);
            ext_clk_i = 1'b0; wait_n(3);
        end
        gate_i = 1'b0;
        wait_n(5);
        rd(1, v); check("R7", "external edges counted", v, 6);
        rd(3, v); check("R7", "gate fall ignored", v, 0);
    endtask

    task automatic t_idle;
        int v;
        do_reset();
        bus_wr(2, 16'hFFFF);
        bus_wr(0, 16'h0021);
        wait_n(4);
        rd(1, v); check("R8", "count before idle", v, 4);
        idle_i = 1'b1;
        wait_n(10);
        rd(1, v); check("R8", "frozen in idle", v, 4);
        idle_i = 1'b0;
        wait_n(3);
        rd(1, v); check("R8", "resumed", v, 7);
        bus_wr(0, 16'h0001);
        idle_i = 1'b1;
        wait_n(4);
        rd(1, v); check("R8", "counts during idle", v, 11);
        idle_i = 1'b0;
    endtask

    task automatic t_clear_collision;
        int v;
        do_reset();
        bus_wr(2, 16'd4);
        bus_wr(0, 16'h0001);
        wait_n(4);
        rd(1, v); check("R9", "count at period", v, 4);
        rd(3, v); check("R9", "flag before collision", v, 0);
        bus_wr(3, 16'h0001);
        rd(1, v); check("R9", "wrapped on collision", v, 0);
        rd(3, v); check("R9", "set wins over clear", v, 1);
    endtask

    task automatic t_disabled;
        int v;
        do_reset();
        bus_wr(2, 16'hFFFF);
        bus_wr(1, 16'd7);
        wait_n(10);
        rd(1, v); check("R11", "disabled holds", v, 7);
    endtask

    task automatic finish_run;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        t_reset();
        t_wrap_irq();
        t_ratio(0, 1);
        t_ratio(1, 8);
        t_ratio(2, 64);
        t_ratio(3, 256);
        t_pre_clear();
        t_load_priority();
        t_gated();
        t_external();
        t_idle();
        t_clear_collision();
        t_disabled();
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end
endmodule